// File: doc/BRIEF.md
# Four-Port Shared RAM

This block is a single-clock random-access memory with one shared storage array and four independent ports: two write ports (A and B) and two read ports (A and B). Each write port carries an address, a data word, one byte-lane enable per lane and a write enable. Each read port registers its address on every rising edge. The stored word at that address reaches the data output either directly (`OUT_REG = 0`) or through one extra output register (`OUT_REG = 1`, the default).

Any of the four ports may touch the same word in the same cycle, and the block defines the outcome of each case. When a write and a read on the same letter hit one address, the read result for that cycle is unspecified. When they are on different letters, read port A returns the freshly written word and read port B returns the word as it stood before the write. When both write ports target one address, port A owns every lane that both ports enable. Two clears act on the outputs: an asynchronous reset and a synchronous clear. A third clear acts only on the two read address registers and forces them to word 0.

Depth, word width and lane width are parameters. The defaults are 512 words of 32 bits in 8-bit lanes. Lane `i` covers data bits `[8*i+7 : 8*i]`, and enable bit `i` controls that lane.

Top module: `quad_port_ram`

## Requirements
- R1: A write on either port with enable high updates only the lanes whose enable bit is 1 (lane `i` = bits `[8i+7:8i]`); all other lanes of that word keep their contents.
- R2: A read address presented before rising edge k shows its word on the read output after edge k when `OUT_REG = 0`, and after edge k+1 when `OUT_REG = 1`; before that point the output still shows the previous read.
- R3: When both write ports target the same address in one cycle, each lane enabled by port A takes port A's data, each lane enabled only by port B takes port B's data, and lanes enabled by neither are unchanged.
- R4: When read port A's address equals write port B's address in the same cycle, and write port A does not hit that address, read port A returns the word including port B's new lanes.
- R5: When read port B's address equals write port A's address in the same cycle, and write port B does not hit that address, read port B returns the word as it was before the write; the next read of that address returns the new word.
- R6: When a read port and the write port of the same letter hit one address in one cycle, that read result is unspecified; the write still completes, and the following read returns the written word.
- R7: While the asynchronous reset `rst_n` is low, both read outputs are 0 immediately and stay 0. Stored words are not cleared.
- R8: With `out_sclr` high at a rising edge, both read outputs are 0 after that edge. Stored words are not affected, and the outputs return to the addressed word after the next edge with `out_sclr` low.
- R9: While `addr_clr_n` is low, both read address registers hold word 0 and ignore the address inputs. The outputs therefore show word 0 (after one edge with `OUT_REG = 1`). Normal addressing resumes after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock; all ports act on its rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of the read outputs |
| addr_clr_n | input | 1 | Asynchronous active-low clear of both read address registers |
| out_sclr | input | 1 | Synchronous clear of both read outputs |
| wa_en | input | 1 | Write port A enable |
| wa_addr | input | 9 | Write port A address |
| wa_be | input | 4 | Write port A lane enables |
| wa_data | input | 32 | Write port A data |
| wb_en | input | 1 | Write port B enable |
| wb_addr | input | 9 | Write port B address |
| wb_be | input | 4 | Write port B lane enables |
| wb_data | input | 32 | Write port B data |
| ra_addr | input | 9 | Read port A address |
| rb_addr | input | 9 | Read port B address |
| rd_a | output | 32 | Read port A data |
| rd_b | output | 32 | Read port B data |

## Verification
The key overlap is a read and a write on different letters hitting one word in the same cycle, which must give new data on read port A and old data on read port B. The bench provokes it by driving write B and read A to one address while write A and read B share a second address in that same edge. It then compares each output with a model updated (for A) or not yet updated (for B), and re-reads B one cycle later to see the new word. The dual-write lane contest and the same-letter collisions are provoked in the same directed way. The unspecified cycle is skipped, and only the following read is compared.

// File: rtl/qpr_pkg.sv
package qpr_pkg;

   // How a read port resolves a same-cycle write from the other letter
   typedef enum logic {
      RD_NEW = 1'b0,   // return the word including the new lanes
      RD_OLD = 1'b1    // return the word as it stood before the edge
   } cross_rule_e;

endpackage

// File: rtl/qpr_array.sv
module qpr_array #(
   parameter int DEPTH  = 512,
   parameter int WIDTH  = 32,
   parameter int LANE_W = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int LANES = WIDTH / LANE_W
) (
   input  logic             clk,
   input  logic             wa_en,
   input  logic [AW-1:0]    wa_addr,
   input  logic [LANES-1:0] wa_be,
   input  logic [WIDTH-1:0] wa_data,
   input  logic             wb_en,
   input  logic [AW-1:0]    wb_addr,
   input  logic [LANES-1:0] wb_be,
   input  logic [WIDTH-1:0] wb_data,
   input  logic [AW-1:0]    rqa_addr,
   input  logic [AW-1:0]    rqb_addr,
   input  logic [AW-1:0]    peek_addr,
   output logic [WIDTH-1:0] rqa_word,
   output logic [WIDTH-1:0] rqb_word,
   output logic [WIDTH-1:0] peek_word
);

   logic [WIDTH-1:0] store [DEPTH];

   // Port B lanes are scheduled first, port A second: on a shared lane the
   // later non-blocking update (port A) is the one that lands.
   always_ff @(posedge clk) begin
      for (int l = 0; l < LANES; l++) begin
         if (wb_en && wb_be[l])
            store[wb_addr][l*LANE_W +: LANE_W] <= wb_data[l*LANE_W +: LANE_W];
         if (wa_en && wa_be[l])
            store[wa_addr][l*LANE_W +: LANE_W] <= wa_data[l*LANE_W +: LANE_W];
      end
   end

   assign rqa_word  = store[rqa_addr];
   assign rqb_word  = store[rqb_addr];
   assign peek_word = store[peek_addr];

endmodule

// File: rtl/qpr_read_port.sv
module qpr_read_port
   import qpr_pkg::*;
#(
   parameter int          AW      = 9,
   parameter int          WIDTH   = 32,
   parameter int          OUT_REG = 1,
   parameter cross_rule_e RULE    = RD_NEW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_clr_n,
   input  logic             out_sclr,
   input  logic [AW-1:0]    addr_i,
   input  logic             cross_hit,
   input  logic [WIDTH-1:0] peek_i,
   input  logic [WIDTH-1:0] word_i,
   output logic [AW-1:0]    addr_q_o,
   output logic [WIDTH-1:0] data_o
);

   logic [AW-1:0]    addr_q;
   logic [WIDTH-1:0] sel_word;

   // Read address register with its own asynchronous clear
   always_ff @(posedge clk or negedge addr_clr_n) begin
      if (!addr_clr_n) addr_q <= '0;
      else             addr_q <= addr_i;
   end
   assign addr_q_o = addr_q;

   generate
      if (RULE == RD_OLD) begin : g_old
         logic             hold_v;
         logic [WIDTH-1:0] hold_q;
         logic             hold_rst_n;
         assign hold_rst_n = rst_n & addr_clr_n;
         // Capture the pre-write word when the other letter writes here
         always_ff @(posedge clk or negedge hold_rst_n) begin
            if (!hold_rst_n) begin
               hold_v <= 1'b0;
               hold_q <= '0;
            end else begin
               hold_v <= cross_hit;
               if (cross_hit) hold_q <= peek_i;
            end
         end
         assign sel_word = hold_v ? hold_q : word_i;
      end else begin : g_new
         logic unused_new;
         assign unused_new = cross_hit ^ (^peek_i);
         assign sel_word   = word_i;
      end
   endgenerate

   generate
      if (OUT_REG != 0) begin : g_oreg
         logic [WIDTH-1:0] out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        out_q <= '0;
            else if (out_sclr) out_q <= '0;
            else               out_q <= sel_word;
         end
         assign data_o = out_q;
      end else begin : g_flow
         logic live_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) live_q <= 1'b0;
            else        live_q <= ~out_sclr;
         end
         assign data_o = live_q ? sel_word : '0;
      end
   endgenerate

endmodule

// File: rtl/quad_port_ram.sv
module quad_port_ram
   import qpr_pkg::*;
#(
   parameter int  DEPTH   = 512,
   parameter int  WIDTH   = 32,
   parameter int  LANE_W  = 8,
   parameter int  OUT_REG = 1,
   localparam int AW      = $clog2(DEPTH),
   localparam int LANES   = WIDTH / LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_clr_n,
   input  logic             out_sclr,
   input  logic             wa_en,
   input  logic [AW-1:0]    wa_addr,
   input  logic [LANES-1:0] wa_be,
   input  logic [WIDTH-1:0] wa_data,
   input  logic             wb_en,
   input  logic [AW-1:0]    wb_addr,
   input  logic [LANES-1:0] wb_be,
   input  logic [WIDTH-1:0] wb_data,
   input  logic [AW-1:0]    ra_addr,
   input  logic [AW-1:0]    rb_addr,
   output logic [WIDTH-1:0] rd_a,
   output logic [WIDTH-1:0] rd_b
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("quad_port_ram: DEPTH must be at least 2");
      end
      if (LANE_W < 1 || (WIDTH % LANE_W) != 0) begin : g_bad_lane
         $error("quad_port_ram: WIDTH must be a whole number of lanes");
      end
      if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_oreg
         $error("quad_port_ram: OUT_REG must be 0 or 1");
      end
   endgenerate

   logic [AW-1:0]    ra_q, rb_q;
   logic [WIDTH-1:0] word_a, word_b, peek_b;
   logic             b_cross_hit;

   // Write port A landing on read port B's address this edge
   assign b_cross_hit = wa_en && (|wa_be) && (wa_addr == rb_addr);

   qpr_array #(
      .DEPTH (DEPTH),
      .WIDTH (WIDTH),
      .LANE_W(LANE_W)
   ) u_array (
      .clk      (clk),
      .wa_en    (wa_en),
      .wa_addr  (wa_addr),
      .wa_be    (wa_be),
      .wa_data  (wa_data),
      .wb_en    (wb_en),
      .wb_addr  (wb_addr),
      .wb_be    (wb_be),
      .wb_data  (wb_data),
      .rqa_addr (ra_q),
      .rqb_addr (rb_q),
      .peek_addr(rb_addr),
      .rqa_word (word_a),
      .rqb_word (word_b),
      .peek_word(peek_b)
   );

   qpr_read_port #(
      .AW     (AW),
      .WIDTH  (WIDTH),
      .OUT_REG(OUT_REG),
      .RULE   (RD_NEW)
   ) u_rd_a (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_clr_n(addr_clr_n),
      .out_sclr  (out_sclr),
      .addr_i    (ra_addr),
      .cross_hit (1'b0),
      .peek_i    ('0),
      .word_i    (word_a),
      .addr_q_o  (ra_q),
      .data_o    (rd_a)
   );

   qpr_read_port #(
      .AW     (AW),
      .WIDTH  (WIDTH),
      .OUT_REG(OUT_REG),
      .RULE   (RD_OLD)
   ) u_rd_b (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_clr_n(addr_clr_n),
      .out_sclr  (out_sclr),
      .addr_i    (rb_addr),
      .cross_hit (b_cross_hit),
      .peek_i    (peek_b),
      .word_i    (word_b),
      .addr_q_o  (rb_q),
      .data_o    (rd_b)
   );

endmodule

// File: rtl/qpr_checker.sv
module qpr_checker #(
   parameter int AW      = 9,
   parameter int WIDTH   = 32,
   parameter int LANES   = 4,
   parameter int OUT_REG = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             addr_clr_n,
   input logic             out_sclr,
   input logic             wa_en,
   input logic [AW-1:0]    wa_addr,
   input logic [LANES-1:0] wa_be,
   input logic             wb_en,
   input logic [AW-1:0]    wb_addr,
   input logic [LANES-1:0] wb_be,
   input logic [WIDTH-1:0] wb_data,
   input logic [AW-1:0]    ra_addr,
   input logic [AW-1:0]    rb_addr,
   input logic [AW-1:0]    ra_q,
   input logic [AW-1:0]    rb_q,
   input logic [WIDTH-1:0] peek_b,
   input logic [WIDTH-1:0] rd_a,
   input logic [WIDTH-1:0] rd_b
);

   logic hit_a, hit_b;
   assign hit_a = wb_en && (&wb_be) && (wb_addr == ra_addr)
                  && !(wa_en && wa_addr == ra_addr) && !out_sclr && addr_clr_n;
   assign hit_b = wa_en && (|wa_be) && (wa_addr == rb_addr)
                  && !(wb_en && wb_addr == rb_addr) && !out_sclr && addr_clr_n;

   // R7
   always @(negedge clk) begin
      if (!rst_n) begin
         reset_zero_chk: assert (rd_a == '0 && rd_b == '0);
      end
   end

   // R8
   sclr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_sclr |=> (rd_a == '0 && rd_b == '0));

   // R9
   addr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_clr_n |-> (ra_q == '0 && rb_q == '0));

   generate
      if (OUT_REG == 0) begin : g_flow_chk
         // R4
         new_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit_a |=> (!addr_clr_n || rd_a == $past(wb_data)));
         // R5
         old_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit_b |=> (!addr_clr_n || rd_b == $past(peek_b)));
      end else begin : g_oreg_chk
         // R4
         new_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit_a ##1 (!out_sclr && addr_clr_n) |=> rd_a == $past(wb_data, 2));
         // R5
         old_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit_b ##1 (!out_sclr && addr_clr_n) |=> rd_b == $past(peek_b, 2));
      end
   endgenerate

endmodule

bind quad_port_ram qpr_checker #(
   .AW     (AW),
   .WIDTH  (WIDTH),
   .LANES  (LANES),
   .OUT_REG(OUT_REG)
) u_qpr_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr_clr_n(addr_clr_n),
   .out_sclr  (out_sclr),
   .wa_en     (wa_en),
   .wa_addr   (wa_addr),
   .wa_be     (wa_be),
   .wb_en     (wb_en),
   .wb_addr   (wb_addr),
   .wb_be     (wb_be),
   .wb_data   (wb_data),
   .ra_addr   (ra_addr),
   .rb_addr   (rb_addr),
   .ra_q      (ra_q),
   .rb_q      (rb_q),
   .peek_b    (peek_b),
   .rd_a      (rd_a),
   .rd_b      (rd_b)
);

// File: tb/test_quad_port_ram.sv
module test_quad_port_ram;

   localparam int DEPTH   = 512;
   localparam int WIDTH   = 32;
   localparam int LANE_W  = 8;
   localparam int OUT_REG = 1;
   localparam int AW      = $clog2(DEPTH);
   localparam int LANES   = WIDTH / LANE_W;
   localparam int LAT     = 1 + OUT_REG;

   logic             clk = 1'b0;
   logic             rst_n, addr_clr_n, out_sclr;
   logic             wa_en, wb_en;
   logic [AW-1:0]    wa_addr, wb_addr, ra_addr, rb_addr;
   logic [LANES-1:0] wa_be, wb_be;
   logic [WIDTH-1:0] wa_data, wb_data;
   logic [WIDTH-1:0] rd_a, rd_b;

   logic [WIDTH-1:0] model [DEPTH];
   int n_run  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   quad_port_ram #(
      .DEPTH(DEPTH), .WIDTH(WIDTH), .LANE_W(LANE_W), .OUT_REG(OUT_REG)
   ) i_quad_port_ram (
      .clk(clk), .rst_n(rst_n), .addr_clr_n(addr_clr_n), .out_sclr(out_sclr),
      .wa_en(wa_en), .wa_addr(wa_addr), .wa_be(wa_be), .wa_data(wa_data),
      .wb_en(wb_en), .wb_addr(wb_addr), .wb_be(wb_be), .wb_data(wb_data),
      .ra_addr(ra_addr), .rb_addr(rb_addr), .rd_a(rd_a), .rd_b(rd_b)
   );

   task automatic check(input string req, input string what,
                        input logic [WIDTH-1:0] got, input logic [WIDTH-1:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s got %h exp %h", req, what, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_writes();
      wa_en = 1'b0; wa_be = '0; wa_addr = '0; wa_data = '0;
      wb_en = 1'b0; wb_be = '0; wb_addr = '0; wb_data = '0;
   endtask

   task automatic model_lanes(input logic [AW-1:0] a, input logic [WIDTH-1:0] d,
                              input logic [LANES-1:0] be);
      for (int l = 0; l < LANES; l++)
         if (be[l]) model[a][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
   endtask

   // One edge carrying both write ports; model applies B first, then A (R3)
   task automatic write2(input logic ae, input logic [AW-1:0] aa, input logic [WIDTH-1:0] ad,
                         input logic [LANES-1:0] ab,
                         input logic be_, input logic [AW-1:0] ba, input logic [WIDTH-1:0] bd,
                         input logic [LANES-1:0] bb);
      wa_en = ae; wa_addr = aa; wa_data = ad; wa_be = ab;
      wb_en = be_; wb_addr = ba; wb_data = bd; wb_be = bb;
      tick();
      if (be_) model_lanes(ba, bd, bb);
      if (ae)  model_lanes(aa, ad, ab);
      idle_writes();
   endtask

   task automatic read2(input logic [AW-1:0] x, input logic [AW-1:0] y, input string req);
      ra_addr = x; rb_addr = y;
      repeat (LAT) tick();
      check(req, "rd_a", rd_a, model[x]);
      check(req, "rd_b", rd_b, model[y]);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; addr_clr_n = 1'b1; out_sclr = 1'b0;
      ra_addr = '0; rb_addr = '0;
      idle_writes();
      repeat (3) tick();
      check("R7", "rd_a in reset", rd_a, '0);
      check("R7", "rd_b in reset", rd_b, '0);
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_fill();
      for (int i = 0; i < 8; i++)
         write2(1'b1, AW'(100 + i), 32'hA000_0000 + 32'(i * 3), '1,
                1'b1, AW'(200 + i), 32'hB000_0000 + 32'(i * 7), '1);
      for (int i = 0; i < 8; i++)
         read2(AW'(100 + i), AW'(207 - i), "R1");
      // R2: latency of one read
      ra_addr = AW'(101);
      repeat (LAT) tick();
      ra_addr = AW'(106);
      if (LAT > 1) begin
         repeat (LAT - 1) tick();
         check("R2", "rd_a before latency", rd_a, model[101]);
      end
      tick();
      check("R2", "rd_a at latency", rd_a, model[106]);
   endtask

   task automatic t_lanes();
      write2(1'b1, AW'(7), 32'h0123_4567, '1, 1'b1, AW'(8), 32'h89AB_CDEF, '1);
      write2(1'b1, AW'(7), 32'hFFFF_FFFF, 4'b1010, 1'b1, AW'(8), 32'h0, 4'b0001);
      read2(AW'(7), AW'(8), "R1");
      check("R1", "lane merge A", model[7], 32'hFF23_FF67);
      check("R1", "lane merge B", model[8], 32'h89AB_CD00);
   endtask

   task automatic t_dual();
      write2(1'b1, AW'(20), 32'hAABB_CCDD, '1, 1'b0, '0, '0, '0);
      write2(1'b1, AW'(20), 32'h1111_1111, 4'b0011, 1'b1, AW'(20), 32'h2222_2222, 4'b0110);
      ra_addr = AW'(20); rb_addr = AW'(20);
      repeat (LAT) tick();
      check("R3", "rd_a dual write", rd_a, 32'hAA22_1111);
      check("R3", "rd_b dual write", rd_b, 32'hAA22_1111);
   endtask

   task automatic t_cross();
      logic [WIDTH-1:0] old_b;
      write2(1'b1, AW'(30), 32'h0, '1, 1'b1, AW'(40), 32'h5555_AAAA, '1);
      write2(1'b1, AW'(31), 32'hAAAA_AAAA, '1, 1'b0, '0, '0, '0);
      // Both cross collisions in one edge
      old_b = model[40];
      ra_addr = AW'(30); rb_addr = AW'(40);
      write2(1'b1, AW'(40), 32'hDEAD_BEEF, '1, 1'b1, AW'(30), 32'hCAFE_F00D, '1);
      repeat (LAT - 1) tick();
      check("R4", "rd_a new data", rd_a, 32'hCAFE_F00D);
      check("R5", "rd_b old data", rd_b, old_b);
      tick();
      check("R5", "rd_b next read", rd_b, 32'hDEAD_BEEF);
      // Partial lanes into read A
      ra_addr = AW'(31);
      write2(1'b0, '0, '0, '0, 1'b1, AW'(31), 32'h1234_5678, 4'b1100);
      repeat (LAT - 1) tick();
      check("R4", "rd_a partial new", rd_a, 32'h1234_AAAA);
   endtask

   task automatic t_same();
      write2(1'b1, AW'(50), 32'h0000_0050, '1, 1'b1, AW'(60), 32'h0000_0060, '1);
      ra_addr = AW'(50); rb_addr = AW'(60);
      write2(1'b1, AW'(50), 32'h5050_5050, '1, 1'b1, AW'(60), 32'h6060_6060, '1);
      // The collision cycle itself is unspecified and not compared
      repeat (LAT - 1) tick();
      tick();
      check("R6", "rd_a after same-letter hit", rd_a, 32'h5050_5050);
      check("R6", "rd_b after same-letter hit", rd_b, 32'h6060_6060);
   endtask

   task automatic t_sclr();
      read2(AW'(101), AW'(202), "R8");
      out_sclr = 1'b1;
      tick();
      check("R8", "rd_a cleared", rd_a, '0);
      check("R8", "rd_b cleared", rd_b, '0);
      out_sclr = 1'b0;
      tick();
      check("R8", "rd_a restored", rd_a, model[101]);
      check("R8", "rd_b restored", rd_b, model[202]);
   endtask

   task automatic t_aclr();
      write2(1'b1, AW'(0), 32'h0BAD_C0DE, '1, 1'b1, AW'(5), 32'h0000_0005, '1);
      write2(1'b1, AW'(6), 32'h0000_0066, '1, 1'b0, '0, '0, '0);
      read2(AW'(5), AW'(5), "R9");
      addr_clr_n = 1'b0;
      tick();
      check("R9", "rd_a word 0", rd_a, 32'h0BAD_C0DE);
      check("R9", "rd_b word 0", rd_b, 32'h0BAD_C0DE);
      ra_addr = AW'(6); rb_addr = AW'(6);
      repeat (2) tick();
      check("R9", "rd_a ignores address", rd_a, 32'h0BAD_C0DE);
      check("R9", "rd_b ignores address", rd_b, 32'h0BAD_C0DE);
      addr_clr_n = 1'b1;
      repeat (LAT) tick();
      check("R9", "rd_a after release", rd_a, 32'h0000_0066);
      check("R9", "rd_b after release", rd_b, 32'h0000_0066);
   endtask

   task automatic t_async_reset();
      read2(AW'(7), AW'(8), "R7");
      #2;
      rst_n = 1'b0;
      #1;
      check("R7", "rd_a async clear", rd_a, '0);
      check("R7", "rd_b async clear", rd_b, '0);
      tick();
      rst_n = 1'b1;
      read2(AW'(7), AW'(8), "R7");
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog (all requirements) got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_fill();
      t_lanes();
      t_dual();
      t_cross();
      t_same();
      t_sclr();
      t_aclr();
      t_async_reset();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule